// File: doc/BRIEF.md
# Programmable Baud Strobe Generator

This block supplies the timing strobes for a serial transmitter and receiver. A down-counter is loaded from a programmable divisor. Each time it expires it emits a single-clock oversampling tick, so the tick rate is the system clock divided by the divisor. For example, a 50 MHz clock with a divisor of 325 gives ticks at roughly 153.85 kHz, which is about 9615 bit/s.

Sixteen ticks make one bit time. A free-running phase counter turns them into a transmit bit strobe. A second phase counter is realigned whenever the receiver reports a start edge, and it fires a sampling strobe in the middle of every received bit. Surrounding logic pulses the load input after it writes either byte of the divisor, and pulses the start input when it sees the falling edge of a start bit.

Top module: `baud_strobe_gen`

## Requirements
- R1: While reset is asserted and on the first sample after it is released, `tick_o`, `tx_bit_o` and `rx_mid_o` are all low.
- R2: When the divisor is 0, `tick_o` stays low for as long as the divisor stays 0.
- R3: With a nonzero divisor N, `tick_o` is a pulse one clock wide that repeats every N clocks. With N = 1 it is high on every clock.
- R4: A `div_load_i` pulse reloads the counter at once from `divisor_i`, dropping any count in progress. The first tick then appears exactly N clocks after the edge that captured the load.
- R5: `tx_bit_o` is high for one clock, in the clock after every 16th tick of a free-running tick count. Successive strobes are 16 ticks (16·N clocks) apart.
- R6: An `rx_start_i` pulse clears the receive phase. A tick that is present in the same clock as the start pulse is discarded, and no `rx_mid_o` is raised in the clock that follows.
- R7: `rx_mid_o` is high for one clock, in the clock after the 8th tick that follows the start edge. After that it repeats every 16 ticks, so the next one follows the 24th tick.
- R8: Whenever `tx_bit_o` or `rx_mid_o` is high, `tick_o` was high in the clock before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| divisor_i | input | 16 | Divisor; 0 stops the ticks |
| div_load_i | input | 1 | One-clock pulse after a divisor write; reloads the counter |
| rx_start_i | input | 1 | One-clock pulse on a detected start edge |
| tick_o | output | 1 | 16x oversampling tick, one clock wide |
| tx_bit_o | output | 1 | Transmit bit-enable strobe |
| rx_mid_o | output | 1 | Mid-bit receive sampling strobe |

## Verification
Every output comes straight from a register. After a load is captured, the first tick appears N edges later. Each strobe appears one edge after the tick that completes its count: the 16th tick for the transmit strobe, and the 8th tick after the start edge for the receive strobe. The bench drives inputs and samples outputs one time unit after each rising edge, and it counts these samples from the edge that captured the stimulus. It then compares tick counts and clock counts against these expected figures instead of waiting for an event with no bound. Divisors of 0, 1, 3, 4 and 5 are covered, along with a reload in the middle of a count and a start pulse that lands on a tick.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
    // Role of a phase counter: free running or realigned by a start edge
    typedef enum logic [0:0] {
        PHASE_FREE    = 1'b0,
        PHASE_ALIGNED = 1'b1
    } phase_mode_e;
endpackage

// File: rtl/bsg_divider.sv
module bsg_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic             load_i,
    output logic             tick_o
);
    localparam logic [DIV_W-1:0] CNT_ONE = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] count;
        logic             tick;
    } div_st_t;

    div_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (load_i) begin
            s_d.count = divisor_i;
        end else if (divisor_i == '0) begin
            s_d.count = '0;
        end else if (s_q.count <= CNT_ONE) begin
            s_d.count = divisor_i;
            s_d.tick  = 1'b1;
        end else begin
            s_d.count = s_q.count - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = s_q.tick;

    // R4: a load leaves the new divisor in the counter and no tick
    a_r4_load_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (s_q.count == $past(divisor_i)) && !s_q.tick);

    // R2: a zero divisor produces no tick
    a_r2_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor_i == '0) |=> !tick_o);

    // R3: a tick that reloaded a count above one is followed by a low clock
    a_r3_tick_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.tick && s_q.count > CNT_ONE) |=> !tick_o);
endmodule

// File: rtl/bsg_phase.sv
module bsg_phase
    import bsg_pkg::*;
#(
    parameter int          OSR       = 16,
    parameter int          STROBE_AT = 15,
    parameter phase_mode_e MODE      = PHASE_FREE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clear_i,
    output logic strobe_o
);
    localparam int             PH_W   = $clog2(OSR);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
    localparam logic [PH_W-1:0] PH_HIT  = PH_W'(STROBE_AT);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            strobe;
    } ph_st_t;

    ph_st_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.strobe = 1'b0;
        if (MODE == PHASE_ALIGNED && clear_i) begin
            s_d.phase = '0;
        end else if (tick_i) begin
            s_d.strobe = (s_q.phase == PH_HIT);
            s_d.phase  = (s_q.phase == PH_LAST) ? '0 : s_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign strobe_o = s_q.strobe;

    // R8: a strobe only follows a tick
    a_r8_strobe_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> $past(tick_i));

    // R5 / R7: strobes are one clock wide
    a_r5_strobe_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    generate
        if (MODE == PHASE_ALIGNED) begin : g_align_chk
            // R6: a start edge clears the phase and suppresses a strobe
            a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
                clear_i |=> (s_q.phase == '0) && !strobe_o);
        end
    endgenerate
endmodule

// File: rtl/baud_strobe_gen.sv
module baud_strobe_gen
    import bsg_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OSR   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic             div_load_i,
    input  logic             rx_start_i,
    output logic             tick_o,
    output logic             tx_bit_o,
    output logic             rx_mid_o
);
    localparam int TX_AT  = OSR - 1;      // phase of the last tick in a bit
    localparam int MID_AT = OSR / 2 - 1;  // phase of the middle tick

    logic tick_w;

    bsg_divider #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .divisor_i (divisor_i),
        .load_i    (div_load_i),
        .tick_o    (tick_w)
    );

    bsg_phase #(.OSR(OSR), .STROBE_AT(TX_AT), .MODE(PHASE_FREE)) u_tx_ph (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_w),
        .clear_i  (1'b0),
        .strobe_o (tx_bit_o)
    );

    bsg_phase #(.OSR(OSR), .STROBE_AT(MID_AT), .MODE(PHASE_ALIGNED)) u_rx_ph (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_w),
        .clear_i  (rx_start_i),
        .strobe_o (rx_mid_o)
    );

    assign tick_o = tick_w;

    // R1: all outputs quiet in the first clock after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !tx_bit_o && !rx_mid_o);
endmodule

// File: tb/sim_baud_strobe_gen.sv
module sim_baud_strobe_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] divisor_i = '0;
    logic        div_load_i = 1'b0;
    logic        rx_start_i = 1'b0;
    logic        tick_o, tx_bit_o, rx_mid_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;  // 250 MHz

    baud_strobe_gen u0 (
        .clk(clk), .rst_n(rst_n), .divisor_i(divisor_i),
        .div_load_i(div_load_i), .rx_start_i(rx_start_i),
        .tick_o(tick_o), .tx_bit_o(tx_bit_o), .rx_mid_o(rx_mid_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input int n);
        divisor_i  = 16'(n);
        div_load_i = 1'b1;
        step();
        div_load_i = 1'b0;
    endtask

    task automatic t_reset();
        chk(!tick_o && !tx_bit_o && !rx_mid_o, "R1 in reset",
            {tick_o, tx_bit_o, rx_mid_o}, 0);
        rst_n = 1'b1;
        step();
        chk(!tx_bit_o && !rx_mid_o, "R1 after release", {tx_bit_o, rx_mid_o}, 0);
    endtask

    // R3 / R4: first tick N clocks after the load, then period N
    task automatic t_period(input int n);
        int k = 0;
        load(n);
        do begin step(); k++; end while (!tick_o && k < n + 5);
        chk(k == n, "R4 first tick delay", k, n);
        for (int g = 0; g < 2; g++) begin
            k = 0;
            do begin
                step(); k++;
                if (n > 1 && k == 1) chk(!tick_o, "R3 tick width", tick_o, 0);
            end while (!tick_o && k < n + 5);
            chk(k == n, "R3 tick period", k, n);
        end
    endtask

    task automatic t_every_clock();
        int hits = 0;
        load(1);
        for (int i = 0; i < 20; i++) begin step(); hits += int'(tick_o); end
        chk(hits == 20, "R3 divisor 1 ticks every clock", hits, 20);
    endtask

    task automatic t_zero();
        int hits = 0;
        load(0);
        for (int i = 0; i < 100; i++) begin step(); hits += int'(tick_o); end
        chk(hits == 0, "R2 divisor 0 silent", hits, 0);
    endtask

    task automatic t_reload();
        int hits = 0;
        load(100);
        for (int i = 0; i < 30; i++) begin step(); hits += int'(tick_o); end
        chk(hits == 0, "R4 no tick before count ends", hits, 0);
        t_period(5);
    endtask

    task automatic t_tx(input int n);
        int k = 0, ticks = 0, cyc = 0;
        bit prev;
        load(n);
        do begin prev = tick_o; step(); k++; end while (!tx_bit_o && k < 40 * n);
        chk(tx_bit_o, "R5 tx strobe seen", tx_bit_o, 1);
        chk(prev, "R8 tx strobe follows tick", prev, 1);
        step(); cyc = 1;
        chk(!tx_bit_o, "R5 tx strobe width", tx_bit_o, 0);
        ticks = int'(tick_o);
        while (cyc < 40 * n) begin
            step(); cyc++;
            if (tx_bit_o) break;
            ticks += int'(tick_o);
        end
        chk(ticks == 16, "R5 ticks per bit", ticks, 16);
        chk(cyc == 16 * n, "R5 clocks per bit", cyc, 16 * n);
    endtask

    task automatic t_rx(input int n);
        int cnt, k = 0;
        bit prev;
        load(n);
        repeat (5) step();
        rx_start_i = 1'b1;
        step();
        rx_start_i = 1'b0;
        chk(!rx_mid_o, "R6 no strobe after start", rx_mid_o, 0);
        cnt = int'(tick_o);
        prev = tick_o;
        while (k < 40 * n) begin
            prev = tick_o; step(); k++;
            if (rx_mid_o) break;
            cnt += int'(tick_o);
        end
        chk(rx_mid_o && cnt == 8, "R7 mid after 8th tick", cnt, 8);
        chk(prev, "R8 mid strobe follows tick", prev, 1);
        cnt += int'(tick_o);
        k = 0;
        while (k < 40 * n) begin
            step(); k++;
            if (rx_mid_o) break;
            cnt += int'(tick_o);
        end
        chk(rx_mid_o && cnt == 24, "R7 next mid after 24th tick", cnt, 24);
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        t_period(3);
        t_every_clock();
        t_zero();
        t_reload();
        t_tx(3);
        t_rx(4);
        t_rx(1);  // R6: start coincides with a tick
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule